// File: doc/BRIEF.md
# Smart Display Serial Transmitter

This block shifts command words and display-data words out to a small smart display panel. It uses a four-wire serial link made of a serial clock, a chip select, a data line and a register-select line. Each word arrives on a valid/ready input together with a flag. The flag says whether the word is a command or pixel/display data. The block drives the register-select line to match that flag for the whole time the word is on the link.

The serial clock comes from the system clock. Its half period is a programmable number of system cycles, so the divider is always even and never less than two. The clock idle level and the chip-select active level are chosen by two independent configuration inputs. Those inputs are expected to change only while the transmitter is idle. Data leaves the block on the clock edge that departs from the idle level. The panel samples it on the following edge, which returns the clock to idle.

Top module: `sdisp_ser_tx`

## Requirements
- R1: `pnl_rs` is 0 while a command word (`in_is_data`=0) is framed by chip select and 1 while a display-data word (`in_is_data`=1) is framed, and it does not change while chip select is active.
- R2: Each word produces exactly WORD_W clock edges leaving the idle level. The bit on `pnl_sdo` at each return-to-idle edge is the next bit of the word, most-significant bit first.
- R3: `pnl_sck` rests at the level of `cfg_ck_idle_hi` (0 = low, 1 = high) whenever chip select is inactive.
- R4: Chip select is active at the level given by `cfg_cs_act_hi` (0 = active low, 1 = active high) and at the opposite level otherwise. All four combinations with R3 work.
- R5: Every clock phase between two consecutive clock edges of a word lasts exactly `cfg_half` system cycles, with 0 treated as 1.
- R6: Chip select becomes active at least one half period before the first clock edge and stays active at least one half period after the last edge.
- R7: Between two words chip select stays inactive for at least two half periods (one full serial clock period).
- R8: A word is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the inter-word gap ends, and input changes during that time do not alter the word being sent.
- R9: While reset is asserted and right after it, including a reset applied in the middle of a word, `in_ready` is 1, chip select is inactive and the clock is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ck_idle_hi | input | 1 | Serial clock idle level |
| cfg_cs_act_hi | input | 1 | Chip-select active level |
| cfg_half | input | HALF_W | Serial clock half period in system cycles (0 acts as 1) |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Transmitter can take a word |
| in_data | input | WORD_W | Word to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| pnl_sck | output | 1 | Serial clock to panel |
| pnl_cs | output | 1 | Chip select to panel |
| pnl_sdo | output | 1 | Serial data to panel |
| pnl_rs | output | 1 | Register select to panel |

## Verification
The embedded assertions take it for granted that `cfg_half`, `cfg_ck_idle_hi` and `cfg_cs_act_hi` stay steady from acceptance until `in_ready` rises again. They also assume reset is the only way to abandon a word. The bench therefore changes configuration only at a falling clock edge while `in_ready` is high. During the busy time it deliberately keeps `in_valid` high and changes `in_data` and `in_is_data`, so any leak of input into a running word would show on the pins.

// File: rtl/sdisp_ser_tx.sv
module sdisp_ser_tx #(
  parameter int WORD_W = 8,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ck_idle_hi,
  input  logic              cfg_cs_act_hi,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_is_data,
  output logic              pnl_sck,
  output logic              pnl_cs,
  output logic              pnl_sdo,
  output logic              pnl_rs
);
  localparam int PH_W = $clog2(2 * WORD_W) + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * WORD_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL, S_GAP} st_t;

  st_t               st;
  logic [HALF_W-1:0] hcnt;
  logic [HALF_W-1:0] half_eff;
  logic [PH_W-1:0]   ph;
  logic [WORD_W-1:0] sreg;
  logic              rs_q;
  logic              sck_act;
  logic              tick;
  logic              cs_on;

  assign half_eff = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
  assign tick     = (hcnt == half_eff - 1'b1);
  assign cs_on    = (st == S_LEAD) || (st == S_SHIFT) || (st == S_TAIL);

  assign in_ready = (st == S_IDLE);
  assign pnl_sck  = sck_act ^ cfg_ck_idle_hi;
  assign pnl_cs   = cs_on ? cfg_cs_act_hi : ~cfg_cs_act_hi;
  assign pnl_sdo  = sreg[WORD_W-1];
  assign pnl_rs   = rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hcnt    <= '0;
      ph      <= '0;
      sreg    <= '0;
      rs_q    <= 1'b0;
      sck_act <= 1'b0;
    end else begin
      if (st == S_IDLE) hcnt <= '0;
      else              hcnt <= tick ? '0 : hcnt + 1'b1;
      case (st)
        S_IDLE: if (in_valid) begin
          sreg <= in_data;
          rs_q <= in_is_data;
          st   <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          st      <= S_SHIFT;
          ph      <= '0;
          sck_act <= 1'b1;
        end
        S_SHIFT: if (tick) begin
          ph <= ph + 1'b1;
          if (!ph[0]) sck_act <= 1'b0;
          else if (ph == PH_LAST) st <= S_TAIL;
          else begin
            sck_act <= 1'b1;
            sreg    <= {sreg[WORD_W-2:0], 1'b0};
          end
        end
        S_TAIL: if (tick) begin
          st <= S_GAP;
          ph <= '0;
        end
        S_GAP: if (tick) begin
          if (ph[0]) st <= S_IDLE;
          ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && $past(cs_on)) |-> $stable(pnl_rs)); // R1
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && !tick) |=> $stable(sreg)); // R2
  AST_CK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |-> (pnl_sck == cfg_ck_idle_hi)); // R3
  AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAIL) |-> !sck_act); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cs_on |-> !in_ready); // R8
  AST_TAKE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (st == S_LEAD && !in_ready)); // R8
endmodule

// File: tb/sdisp_ser_tx_tb.sv
module sdisp_ser_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ck_idle_hi = 1'b0, cfg_cs_act_hi = 1'b0;
  logic [7:0] cfg_half = 8'd2;
  logic in_valid = 1'b0, in_is_data = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, pnl_sck, pnl_cs, pnl_sdo, pnl_rs;
  int errors = 0, total = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdisp_ser_tx #(.WORD_W(8), .HALF_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ck_idle_hi(cfg_ck_idle_hi), .cfg_cs_act_hi(cfg_cs_act_hi),
    .cfg_half(cfg_half), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_is_data(in_is_data), .pnl_sck(pnl_sck), .pnl_cs(pnl_cs), .pnl_sdo(pnl_sdo), .pnl_rs(pnl_rs));

  // {idle_hi, cs_hi, half[7:0], is_data, word[7:0]}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'd1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 8'd2, 1'b1, 8'h3C},
    {1'b0, 1'b1, 8'd3, 1'b1, 8'h81},
    {1'b1, 1'b1, 8'd1, 1'b0, 8'h7E},
    {1'b0, 1'b0, 8'd4, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'd2, 1'b1, 8'hFF},
    {1'b0, 1'b1, 8'd0, 1'b0, 8'h96},
    {1'b1, 1'b0, 8'd5, 1'b0, 8'h01}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  endtask

  task automatic send(input logic ckhi, input logic cshi, input logic [7:0] half,
                      input logic isd, input logic [7:0] word);
    int h, lead, run, ledges, gap, guard;
    logic [7:0] got;
    logic prev, csa, seen_off, rs_bad, rdy_bad, idle_bad, ph_bad;
    h = (half == 8'd0) ? 1 : int'(half);
    lead = 0; run = 0; ledges = 0; gap = 0; guard = 0; got = 8'h00;
    seen_off = 0; rs_bad = 0; rdy_bad = 0; idle_bad = 0; ph_bad = 0;
    @(negedge clk);
    cfg_ck_idle_hi = ckhi; cfg_cs_act_hi = cshi; cfg_half = half;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready while idle", int'(in_ready), 1);
    chk(pnl_cs == !cshi, "R4 inactive cs level", int'(pnl_cs), int'(!cshi));
    chk(pnl_sck == ckhi, "R3 clock idle level", int'(pnl_sck), int'(ckhi));
    in_valid = 1'b1; in_data = word; in_is_data = isd;
    @(negedge clk);
    in_data = ~word; in_is_data = ~isd;
    chk(pnl_cs == cshi, "R4 active cs level", int'(pnl_cs), int'(cshi));
    prev = ckhi;
    while (guard < 5000) begin
      guard++;
      csa = (pnl_cs == cshi);
      if (csa) begin
        if (pnl_rs != isd) rs_bad = 1;
        if (in_ready) rdy_bad = 1;
      end else if (pnl_sck != ckhi) idle_bad = 1;
      if (pnl_sck != prev) begin
        if (pnl_sck != ckhi) begin
          ledges++;
          if (ledges == 1) chk(lead >= h, "R6 cs lead before first edge", lead, h);
          else if (run != h) ph_bad = 1;
        end else begin
          got = {got[6:0], pnl_sdo};
          if (run != h) ph_bad = 1;
        end
        run = 1;
        prev = pnl_sck;
      end else begin
        if (csa && ledges == 0) lead++;
        if (!csa && !seen_off && ledges > 0) begin
          seen_off = 1;
          chk(run >= h, "R6 cs hold after last edge", run, h);
          in_valid = 1'b0;
        end
        if (!csa && seen_off && !in_ready) gap++;
        if (seen_off && in_ready) break;
        run++;
      end
      @(negedge clk);
    end
    chk(!rs_bad, "R1 register select level", int'(pnl_rs), int'(isd));
    chk(!rdy_bad, "R8 ready low while busy", 1, 0);
    chk(!idle_bad, "R3 clock idle while cs inactive", 1, 0);
    chk(!ph_bad, "R5 clock phase length", run, h);
    chk(ledges == 8, "R2 leading edge count", ledges, 8);
    chk(got == word, "R2 MSB-first word", int'(got), int'(word));
    chk(gap >= 2 * h, "R7 inter-word gap", gap, 2 * h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready in reset", int'(in_ready), 1);
    chk(pnl_cs == 1'b1, "R9 cs inactive in reset", int'(pnl_cs), 1);
    chk(pnl_sck == 1'b0, "R9 clock idle in reset", int'(pnl_sck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);

    for (int i = 0; i < 8; i++)
      send(VEC[i][18], VEC[i][17], VEC[i][16:9], VEC[i][8], VEC[i][7:0]);

    // reset in the middle of a word
    @(negedge clk);
    cfg_ck_idle_hi = 1'b1; cfg_cs_act_hi = 1'b1; cfg_half = 8'd3;
    in_valid = 1'b1; in_data = 8'hC3; in_is_data = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(pnl_cs == 1'b1, "R4 cs active mid word", int'(pnl_cs), 1);
    rst_n = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R9 ready after mid-word reset", int'(in_ready), 1);
    chk(pnl_cs == 1'b0, "R9 cs released by reset", int'(pnl_cs), 0);
    chk(pnl_sck == 1'b1, "R9 clock idle after reset", int'(pnl_sck), 1);
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b1, 1'b1, 8'd1, 1'b0, 8'h5A);
    finish_run();
  end
endmodule